// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Target Engine

This block is the bus-facing engine of a byte-addressed serial EEPROM. It watches the SCL and SDA wires through a system-clock sampler, spots START, repeated START and STOP, and runs the byte-level protocol of a two-wire memory target. It accepts a device-select byte, a two-byte word address and any number of write-data bytes. It can also stream data back to the master from a persistent internal address counter. SDA is driven only as an open-drain pull-down enable. The byte store is modelled inside the block as a plain synchronous RAM of `2**ADDR_W` bytes. The default is 512 bytes, so that elaboration stays small.

A separate write-cycle block sits next to this engine. It receives a one-clock pulse when a STOP closes a write that carried accepted data. While it is busy it holds `wr_busy_i` high, and the engine then refuses its select byte, so a master can poll for completion. A write-protect input is sampled once per write, on the SCL falling edge that opens the first data byte. When it is set, the whole write is refused.

Top module: `eeprom_i2c_target`

## Requirements
- R1: A select byte is accepted only when its upper four bits are 1010 and bits 3..1 equal `strap_i[2:0]`; bit 0 is R/W (1 = read, 0 = write). Any other select byte is not acknowledged, and every later byte is ignored and left unacknowledged until the next START.
- R2: The engine acknowledges by pulling SDA low during the ninth SCL clock after an accepted select byte, after each word-address byte, and after each accepted write-data byte.
- R3: The word address arrives high byte first. Only its low `ADDR_W` bits form the byte address and the bits above are ignored.
- R4: Incoming bits are taken on the SCL rising edge. `sda_oe_o` changes only after an SCL falling edge or a START/STOP, so read data stays stable while SCL is high.
- R5: A read with no preceding address returns the byte at the internal counter. The counter points one past the last byte read or written, and it wraps from the last location to location 0.
- R6: A random read is made of a write select, two address bytes, a repeated START and a read select. It returns the byte at the given address.
- R7: In a read, every master ACK makes the engine send the next byte, wrapping at the end of memory. After a master NACK, SDA is released and stays released until the next START.
- R8: Write data goes to consecutive locations. Only the low `PAGE_W` address bits advance, so data that passes the page end wraps to the start of the same page.
- R9: While `wr_busy_i` is high at the end of a select byte, that select byte is not acknowledged.
- R10: `wp_i` is sampled on the SCL falling edge that ends the ACK of the low address byte. If it was 1, the first data byte is not acknowledged, nothing is stored, and no write cycle is requested.
- R11: A STOP that follows at least one accepted data byte pulses `wcycle_start_o` high for exactly one clock. A STOP after a read or after an address-only write does not.
- R12: A START or STOP at any bit position aborts the byte in progress, releases SDA and restarts the engine cleanly.
- R13: During and after reset `sda_oe_o` and `wcycle_start_o` are 0 and the internal address counter is 0. The RAM contents are not changed by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to sample the bus |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock wire level |
| sda_i | input | 1 | Serial data wire level |
| sda_oe_o | output | 1 | 1 pulls SDA low; 0 releases it |
| strap_i | input | 3 | Board-level device address bits matched by the select byte |
| wp_i | input | 1 | Write-protect level, 1 refuses writes |
| wr_busy_i | input | 1 | High while the write-cycle block is busy |
| wcycle_start_o | output | 1 | One-clock request to start the internal write cycle |

## Verification
The bench writes across a page end and checks that the second byte lands at the start of the same page. A design that carried into the page bits would instead corrupt the next page. A sequential read starting at the last location must continue at location 0, and a following current-address read must return location 1; an off-by-one counter shows up as a wrong byte there. Write-protect, busy and a wrong strap must each leave a refused byte unacknowledged, with memory unchanged and no write-cycle pulse. A STOP in the middle of an address byte must leave SDA free, and the next transfer must still work, which catches a bit counter that does not resynchronise.

// File: rtl/eeprom_i2c_pkg.sv
package eeprom_i2c_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_AHI,
        ST_ALO,
        ST_WDAT,
        ST_RDAT,
        ST_SKIP
    } tgt_state_e;

    localparam logic [3:0] SEL_PATTERN = 4'b1010;

endpackage

// File: rtl/i2c_line_sampler.sv
module i2c_line_sampler #(
    parameter int SYNC_N = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    localparam int HIST = SYNC_N + 1;

    logic [HIST-1:0] scl_q, sda_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            scl_q <= '1;
            sda_q <= '1;
        end else begin
            scl_q <= {scl_q[HIST-2:0], scl_i};
            sda_q <= {sda_q[HIST-2:0], sda_i};
        end
    end

    // index SYNC_N-1 is the settled level, SYNC_N the previous one
    assign sda_s_o    = sda_q[SYNC_N-1];
    assign scl_rise_o =  scl_q[SYNC_N-1] & ~scl_q[SYNC_N];
    assign scl_fall_o = ~scl_q[SYNC_N-1] &  scl_q[SYNC_N];
    assign start_o    =  scl_q[SYNC_N-1] &  scl_q[SYNC_N] & ~sda_q[SYNC_N-1] &  sda_q[SYNC_N];
    assign stop_o     =  scl_q[SYNC_N-1] &  scl_q[SYNC_N] &  sda_q[SYNC_N-1] & ~sda_q[SYNC_N];

endmodule

// File: rtl/eeprom_byte_ram.sv
module eeprom_byte_ram #(
    parameter int AW = 9,
    parameter int DW = 8
) (
    input  logic          clk_i,
    input  logic          we_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rdata_o
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk_i) begin
        if (we_i) begin
            mem[addr_i] <= wdata_i;
        end
        rdata_o <= mem[addr_i];
    end

endmodule

// File: rtl/eeprom_i2c_target.sv
module eeprom_i2c_target
    import eeprom_i2c_pkg::*;
#(
    parameter int ADDR_W = 9,   // 9..16
    parameter int PAGE_W = 6
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe_o,
    input  logic [2:0] strap_i,
    input  logic       wp_i,
    input  logic       wr_busy_i,
    output logic       wcycle_start_o
);
    localparam int BYTE_W = 8;

    typedef struct packed {
        tgt_state_e        st;
        logic [3:0]        cnt;
        logic [BYTE_W-1:0] sh;
        logic [ADDR_W-1:0] addr;
        logic              oe;
        logic              rw;
        logic              wp;
        logic              wrote;
        logic              mack;
        logic              wcyc;
    } eng_t;

    localparam eng_t ENG_RST = '{st: ST_IDLE, cnt: '0, sh: '0, addr: '0, oe: 1'b0,
                                 rw: 1'b0, wp: 1'b0, wrote: 1'b0, mack: 1'b0, wcyc: 1'b0};

    logic sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic mem_we;
    logic [BYTE_W-1:0] rdata;
    eng_t q, n;

    i2c_line_sampler #(.SYNC_N(2)) smp_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_s_o   (sda_s),
        .scl_rise_o(scl_rise),
        .scl_fall_o(scl_fall),
        .start_o   (start_det),
        .stop_o    (stop_det)
    );

    eeprom_byte_ram #(.AW(ADDR_W), .DW(BYTE_W)) ram_i (
        .clk_i  (clk_i),
        .we_i   (mem_we),
        .addr_i (q.addr),
        .wdata_i(q.sh),
        .rdata_o(rdata)
    );

    always_comb begin
        n      = q;
        n.wcyc = 1'b0;
        mem_we = 1'b0;
        if (stop_det) begin
            n.wcyc  = q.wrote;
            n.st    = ST_IDLE;
            n.cnt   = '0;
            n.oe    = 1'b0;
            n.wrote = 1'b0;
        end else if (start_det) begin
            n.st    = ST_DEV;
            n.cnt   = '0;
            n.oe    = 1'b0;
            n.wrote = 1'b0;
        end else if (q.st == ST_RDAT) begin
            if (scl_rise) begin
                if (q.cnt < 4'd8)       n.cnt  = q.cnt + 4'd1;
                else if (q.cnt == 4'd9) n.mack = ~sda_s;
            end
            if (scl_fall) begin
                if (q.cnt inside {[4'd1:4'd7]}) begin
                    n.sh = {q.sh[BYTE_W-2:0], 1'b0};
                    n.oe = ~q.sh[BYTE_W-2];
                end else if (q.cnt == 4'd8) begin
                    n.oe  = 1'b0;
                    n.cnt = 4'd9;
                end else if (q.cnt == 4'd9) begin
                    if (q.mack) begin
                        n.sh   = rdata;
                        n.oe   = ~rdata[BYTE_W-1];
                        n.addr = q.addr + ADDR_W'(1);
                        n.cnt  = '0;
                    end else begin
                        n.oe = 1'b0;
                        n.st = ST_SKIP;
                    end
                end
            end
        end else if (q.st != ST_IDLE && q.st != ST_SKIP) begin
            if (scl_rise && q.cnt < 4'd8) begin
                n.sh  = {q.sh[BYTE_W-2:0], sda_s};
                n.cnt = q.cnt + 4'd1;
            end
            if (scl_fall && q.cnt == 4'd8) begin
                n.cnt = 4'd9;
                n.oe  = 1'b1;
                case (q.st)
                    ST_DEV: begin
                        if (q.sh[7:4] == SEL_PATTERN && q.sh[3:1] == strap_i && !wr_busy_i) begin
                            n.rw = q.sh[0];
                        end else begin
                            n.oe = 1'b0;
                            n.st = ST_SKIP;
                        end
                    end
                    ST_AHI: n.addr = ADDR_W'({q.sh, q.addr[7:0]});
                    ST_ALO: n.addr[7:0] = q.sh;
                    ST_WDAT: begin
                        if (q.wp) begin
                            n.oe = 1'b0;
                            n.st = ST_SKIP;
                        end else begin
                            mem_we  = 1'b1;
                            n.wrote = 1'b1;
                            n.addr  = {q.addr[ADDR_W-1:PAGE_W], q.addr[PAGE_W-1:0] + PAGE_W'(1)};
                        end
                    end
                    default: n.oe = 1'b0;
                endcase
            end
            if (scl_fall && q.cnt == 4'd9) begin
                n.oe  = 1'b0;
                n.cnt = '0;
                case (q.st)
                    ST_DEV: begin
                        if (q.rw) begin
                            n.st   = ST_RDAT;
                            n.sh   = rdata;
                            n.oe   = ~rdata[BYTE_W-1];
                            n.addr = q.addr + ADDR_W'(1);
                        end else begin
                            n.st = ST_AHI;
                        end
                    end
                    ST_AHI:  n.st = ST_ALO;
                    ST_ALO: begin
                        n.st = ST_WDAT;
                        n.wp = wp_i;
                    end
                    default: n.st = q.st;
                endcase
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= ENG_RST;
        else         q <= n;
    end

    assign sda_oe_o       = q.oe;
    assign wcycle_start_o = q.wcyc;

endmodule

// File: rtl/eeprom_i2c_target_chk.sv
module eeprom_i2c_target_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic sda_oe_o,
    input logic wcycle_start_o,
    input logic stop_det,
    input logic scl_fall,
    input logic mem_we
);
    // R12: a STOP always leaves SDA released on the next clock
    assert_stop_release_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stop_det |=> !sda_oe_o);

    // R11: the write-cycle request lasts a single clock
    assert_wcycle_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wcycle_start_o |=> !wcycle_start_o);

    // R11: the write-cycle request only follows a STOP
    assert_wcycle_after_stop_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wcycle_start_o |-> $past(stop_det));

    // R4: SDA is only pulled low right after an SCL falling edge
    assert_oe_on_fall_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(sda_oe_o) |-> $past(scl_fall));

    // R2: every stored byte is acknowledged
    assert_write_acked_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mem_we |=> sda_oe_o);
endmodule

bind eeprom_i2c_target eeprom_i2c_target_chk chk_i (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .sda_oe_o      (sda_oe_o),
    .wcycle_start_o(wcycle_start_o),
    .stop_det      (stop_det),
    .scl_fall      (scl_fall),
    .mem_we        (mem_we)
);

// File: tb/eeprom_i2c_target_tb_top.sv
module eeprom_i2c_target_tb_top;
    localparam int Q = 8;
    localparam logic [2:0] STRAP = 3'b101;
    localparam logic [7:0] SEL_W = {4'b1010, STRAP, 1'b0};
    localparam logic [7:0] SEL_R = {4'b1010, STRAP, 1'b1};
    localparam int NV = 6;
    // {word address, data}
    localparam logic [23:0] VEC [NV] = '{
        {16'h0000, 8'h3C}, {16'h0001, 8'h96}, {16'h01FF, 8'hA5},
        {16'h0040, 8'h0F}, {16'h00AA, 8'h55}, {16'h0100, 8'hC3}};

    logic clk = 1'b0, rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1, wp = 1'b0, busy = 1'b0;
    logic sda_oe, wcyc, sda_line;
    int checks = 0, errors = 0, wc_cnt = 0, hold_viol = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;
    assign sda_line = sda_m & ~sda_oe;

    eeprom_i2c_target dut_i (
        .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_oe_o(sda_oe), .strap_i(STRAP), .wp_i(wp), .wr_busy_i(busy),
        .wcycle_start_o(wcyc));

    always @(posedge clk) if (wcyc) wc_cnt <= wc_cnt + 1;

    task automatic tick(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_start;
        sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(2*Q);
    endtask

    task automatic put_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(2*Q); scl_m = 1'b1; tick(2*Q); scl_m = 1'b0;
        end
        sda_m = 1'b1; tick(2*Q); scl_m = 1'b1; tick(Q);
        acked = ~sda_line;
        tick(Q); scl_m = 1'b0;
    endtask

    task automatic get_byte(input logic mack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(2*Q); scl_m = 1'b1; tick(Q);
            b[i] = sda_line;
            tick(Q-1);
            if (sda_line !== b[i]) hold_viol++;
            tick(1); scl_m = 1'b0;
        end
        sda_m = ~mack; tick(2*Q); scl_m = 1'b1; tick(2*Q); scl_m = 1'b0;
    endtask

    task automatic wr_byte(input logic [15:0] a, input logic [7:0] d, output logic [3:0] acks);
        bus_start;
        put_byte(SEL_W, acks[3]); put_byte(a[15:8], acks[2]);
        put_byte(a[7:0], acks[1]); put_byte(d, acks[0]);
        bus_stop;
    endtask

    task automatic rd_rand(input logic [15:0] a, input logic two,
                           output logic [7:0] b0, output logic [7:0] b1, output logic [3:0] acks);
        bus_start;
        put_byte(SEL_W, acks[3]); put_byte(a[15:8], acks[2]); put_byte(a[7:0], acks[1]);
        bus_start;
        put_byte(SEL_R, acks[0]);
        get_byte(two, b0);
        b1 = 8'h00;
        if (two) get_byte(1'b0, b1);
        bus_stop;
    endtask

    task automatic rd_cur(output logic [7:0] b, output logic ack);
        bus_start; put_byte(SEL_R, ack); get_byte(1'b0, b); bus_stop;
    endtask

    initial begin
        logic [7:0] b0, b1;
        logic [3:0] acks;
        logic ack;
        int wc0;
        tick(4);
        chk("R13 oe in reset", 16'(sda_oe), 16'h0);
        chk("R13 wcycle in reset", 16'(wcyc), 16'h0);
        rst_n = 1'b1; tick(4);
        chk("R13 oe after reset", 16'(sda_oe), 16'h0);

        // vector table: byte write, then random read back
        for (int v = 0; v < NV; v++) begin
            wc0 = wc_cnt;
            wr_byte(VEC[v][23:8], VEC[v][7:0], acks);
            chk("R2 write acks", 16'(acks), 16'hF);
            chk("R11 write cycle after data", 16'(wc_cnt - wc0), 16'h1);
            wc0 = wc_cnt;
            rd_rand(VEC[v][23:8], 1'b0, b0, b1, acks);
            chk("R6 random read data", 16'(b0), 16'(VEC[v][7:0]));
            chk("R2 random read acks", 16'(acks), 16'hF);
            chk("R11 no cycle after dummy write", 16'(wc_cnt - wc0), 16'h0);
        end

        // R5 / R7: sequential read wrapping past the end of memory
        rd_rand(16'h01FF, 1'b1, b0, b1, acks);
        chk("R7 seq first byte", 16'(b0), 16'h00A5);
        chk("R5 wrap to location 0", 16'(b1), 16'h003C);
        rd_cur(b0, ack);
        chk("R5 current address read", 16'(b0), 16'h0096);

        // R7: NACK releases SDA
        bus_start; put_byte(SEL_R, ack); get_byte(1'b0, b0); tick(Q);
        chk("R7 SDA released after NACK", 16'(sda_oe), 16'h0);
        bus_stop;

        // R13: counter back to 0 after reset, RAM kept
        rst_n = 1'b0; tick(3); rst_n = 1'b1; tick(3);
        rd_cur(b0, ack);
        chk("R13 counter reset to 0", 16'(b0), 16'h003C);

        // R1: wrong strap, wrong pattern, then ignored until START
        bus_start; put_byte({4'b1010, 3'b011, 1'b1}, ack);
        chk("R1 wrong strap not acked", 16'(ack), 16'h0);
        put_byte(SEL_R, ack);
        chk("R1 ignored until next START", 16'(ack), 16'h0);
        bus_stop;
        bus_start; put_byte({4'b1011, STRAP, 1'b1}, ack);
        chk("R1 wrong pattern not acked", 16'(ack), 16'h0);
        bus_stop;

        // R9: busy write cycle refuses the select byte
        busy = 1'b1;
        bus_start; put_byte(SEL_R, ack); bus_stop;
        chk("R9 select NACK while busy", 16'(ack), 16'h0);
        busy = 1'b0;
        rd_cur(b0, ack);
        chk("R9 select ACK when idle", 16'(ack), 16'h1);

        // R10: write protect
        wp = 1'b1; wc0 = wc_cnt;
        wr_byte(16'h0040, 8'h77, acks);
        wp = 1'b0;
        chk("R10 data byte refused", 16'(acks), 16'hE);
        chk("R10 no write cycle", 16'(wc_cnt - wc0), 16'h0);
        rd_rand(16'h0040, 1'b0, b0, b1, acks);
        chk("R10 memory unchanged", 16'(b0), 16'h000F);

        // R8: page wrap on write
        wc0 = wc_cnt;
        bus_start;
        put_byte(SEL_W, acks[3]); put_byte(8'h00, acks[2]); put_byte(8'h7F, acks[1]);
        put_byte(8'h11, acks[0]); put_byte(8'h22, ack);
        bus_stop;
        chk("R8 two data acks", 16'({acks, ack}), 16'h1F);
        chk("R11 one cycle per write", 16'(wc_cnt - wc0), 16'h1);
        rd_rand(16'h007F, 1'b0, b0, b1, acks);
        chk("R8 page last byte", 16'(b0), 16'h0011);
        rd_rand(16'h0040, 1'b0, b0, b1, acks);
        chk("R8 wrapped to page start", 16'(b0), 16'h0022);

        // R3: upper address bits ignored
        wr_byte(16'hFE23, 8'h6B, acks);
        rd_rand(16'h0023, 1'b0, b0, b1, acks);
        chk("R3 upper bits ignored", 16'(b0), 16'h006B);

        // R12: STOP in the middle of an address byte
        wc0 = wc_cnt;
        bus_start; put_byte(SEL_W, ack); put_byte(8'h00, ack);
        for (int i = 0; i < 3; i++) begin
            sda_m = 1'b1; tick(2*Q); scl_m = 1'b1; tick(2*Q); scl_m = 1'b0;
        end
        bus_stop;
        chk("R12 SDA released after abort", 16'(sda_oe), 16'h0);
        chk("R12 no write cycle after abort", 16'(wc_cnt - wc0), 16'h0);
        rd_rand(16'h00AA, 1'b0, b0, b1, acks);
        chk("R12 engine resynchronised", 16'(b0), 16'h0055);

        chk("R4 read data stable while SCL high", 16'(hold_viol), 16'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule